// File: doc/BRIEF.md
# Cartridge Bank Address Translator

This block converts CPU and picture-bus addresses into physical addresses for a banked cartridge. It reads four 5-bit configuration words that a separate loader keeps up to date: a control word, two character-bank words and a program-bank word. From them it produces a program-ROM address, a work-RAM address and a character-memory address, each with its own select line. It also outputs the nametable mirroring mode and the work-RAM enable.

The program window at $8000-$FFFF is built from 16K banks and can be used in one of four modes. The work-RAM window at $6000-$7FFF is a single 8K page. The picture-bus window at $0000-$1FFF is built from 4K character banks, either as one 8K pair or as two independent 4K banks.

When the program ROM is 512K, bit 4 of a character-bank word supplies the outer program address bit. Two more variants are set by parameters. One is a fixed-32K board that ignores program banking. The other is an early chip revision on which work RAM can never be disabled. Every output is registered, so each one reflects the inputs from the previous clock edge.

Top module: `cart_bank_xlate`

## Requirements
- R1: The `mirror` output equals control bits 1:0 (0 = one-screen lower, 1 = one-screen upper, 2 = vertical, 3 = horizontal). Reset drives it to 0, one-screen lower.
- R2: For program modes 0 and 1 (control bits 3:2), the program address is `{bank[3:1], cpu_addr[14:0]}`, so bit 0 of the program-bank word has no effect.
- R3: In program mode 2, $8000-$BFFF maps to 16K bank 0 and $C000-$FFFF maps to the bank in program-bank bits 3:0.
- R4: In program mode 3, $8000-$BFFF maps to the bank in program-bank bits 3:0 and $C000-$FFFF maps to the last 16K bank. The last bank is derived from the ROM size.
- R5: An access to $6000-$7FFF raises `wram_sel` with `wram_addr = cpu_addr[12:0]` only while `wram_en` is 1. `wram_en` is the inverse of program-bank bit 4.
- R6: With control bit 4 set to 1, picture addresses $0000-$0FFF use character-bank 0 and $1000-$1FFF use character-bank 1. Each is a 4K bank, and the address is `{bank, ppu_addr[11:0]}`.
- R7: With control bit 4 set to 0, the picture address is `{chr0[4:1], ppu_addr[12:0]}`, and character-bank 1 has no effect.
- R8: With 512K program ROM, the outer program address bit 18 comes from character-bank 1 bit 4 when `last_wr_chr1` is 1 and control bit 4 is 1. Otherwise it comes from character-bank 0 bit 4. It applies to both 16K halves, including the fixed last bank.
- R9: Program and character bank numbers wrap modulo the number of banks present.
- R10: An access outside the three windows leaves its select at 0 and its address output at 0. This covers CPU addresses below $6000 and picture addresses at $2000 or above.
- R11: With FIXED32 set, $8000-$FFFF always maps to the first 32K (`{0, cpu_addr[14:0]}`), whatever the mode and bank values.
- R12: With REV_A set, `wram_en` is 1 and work RAM stays selectable even when program-bank bit 4 is 1.
- R13: All outputs change one clock after their inputs. A synchronous reset clears every select, every address and `wram_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_addr | input | 16 | CPU bus address |
| ppu_addr | input | 14 | Picture bus address |
| ctrl_reg | input | 5 | Control word: mirroring, program mode, character mode |
| chr0_reg | input | 5 | Character bank word 0 |
| chr1_reg | input | 5 | Character bank word 1 |
| prg_reg | input | 5 | Program bank word and work-RAM disable |
| last_wr_chr1 | input | 1 | Last register write targeted $C000-$DFFF |
| prg_sel | output | 1 | Program ROM selected |
| prg_addr | output | PRG_AW | Program ROM physical address |
| wram_sel | output | 1 | Work RAM selected |
| wram_addr | output | 13 | Work RAM address |
| chr_sel | output | 1 | Character memory selected |
| chr_addr | output | CHR_AW | Character memory physical address |
| mirror | output | 2 | Nametable mirroring mode |
| wram_en | output | 1 | Work RAM enabled |

## Verification
The main translation is tried with each program mode at addresses in both 16K halves, so that the fixed-first, fixed-last and switchable paths are each seen. Bank values are chosen with bit 0 set, which shows whether the 32K modes really drop it. Character patterns place distinct values in the two bank words and probe both 4K halves, which tells the 4K mode apart from the 8K mode. Separate instances with 128K, 512K and fixed-32K program ROM cover wrapping, the choice of source for the outer bit, and the revision and board variants.

// File: rtl/cart_xlate_pkg.sv
// Shared types for the cartridge bank address translator.
// Assumes 5-bit configuration words as produced by the serial loader.
package cart_xlate_pkg;

    typedef enum logic [1:0] {
        MIR_ONE_LO = 2'd0,
        MIR_ONE_HI = 2'd1,
        MIR_VERT   = 2'd2,
        MIR_HORZ   = 2'd3
    } mirror_e;

    typedef enum logic [1:0] {
        PM_WIDE_A   = 2'd0,
        PM_WIDE_B   = 2'd1,
        PM_FIX_HEAD = 2'd2,
        PM_FIX_TAIL = 2'd3
    } prg_mode_e;

    typedef struct packed {
        logic prg;
        logic wram;
    } cpu_win_t;

    localparam int CFG_W     = 5;
    localparam int WRAM_AW   = 13;
    localparam int PRG_PAGE  = 14;
    localparam int CHR_PAGE  = 12;

endpackage

// File: rtl/cpu_window_dec.sv
// Decodes the CPU address into the program and work-RAM windows.
// Assumes a 16-bit CPU address; the program window is the upper half,
// the work-RAM window is $6000-$7FFF.
module cpu_window_dec
    import cart_xlate_pkg::*;
(
    input  logic [15:0] cpu_addr,
    output cpu_win_t    win
);

    // Window classification from the top address bits.
    always_comb begin
        win.prg  = cpu_addr[15];
        win.wram = (cpu_addr[15:13] == 3'b011);
    end

endmodule

// File: rtl/prg_bank_map.sv
// Forms the 16K program bank number for the current CPU address.
// Assumes a power-of-two ROM between 32K and 512K; bank numbers are
// truncated to the bank count, which gives modulo wrap. The outer bit
// survives only when the ROM is 512K.
module prg_bank_map
    import cart_xlate_pkg::*;
#(
    parameter int PRG_AW  = 18,
    parameter bit FIXED32 = 1'b0,
    localparam int BW     = PRG_AW - PRG_PAGE
) (
    input  prg_mode_e       mode,
    input  logic [3:0]      bank,
    input  logic            outer,
    input  logic            upper_half,
    output logic [BW-1:0]   bank16
);

    localparam int NBANKS     = 1 << BW;
    localparam int INNER_CNT  = (NBANKS > 16) ? 16 : NBANKS;
    localparam logic [3:0] LAST_INNER = 4'(INNER_CNT - 1);

    logic [3:0] inner;
    logic [4:0] full;

    // Inner bank choice by program mode.
    always_comb begin
        unique case (mode)
            PM_WIDE_A, PM_WIDE_B: inner = {bank[3:1], upper_half};
            PM_FIX_HEAD:          inner = upper_half ? bank : 4'd0;
            PM_FIX_TAIL:          inner = upper_half ? LAST_INNER : bank;
            default:              inner = bank;
        endcase
    end

    generate
        if (FIXED32) begin : g_fixed
            // Board variant: first 32K, no banking.
            always_comb full = {4'd0, upper_half};
        end else begin : g_banked
            // Banked board: outer bit on top of the inner bank.
            always_comb full = {outer, inner};
        end
    endgenerate

    // Truncate to the bank count present.
    always_comb bank16 = full[BW-1:0];

endmodule

// File: rtl/chr_bank_map.sv
// Forms the 4K character bank number for the current picture address.
// Assumes a power-of-two character memory of 8K to 128K; truncation of
// the bank number gives modulo wrap.
module chr_bank_map
    import cart_xlate_pkg::*;
#(
    parameter int CHR_AW = 17,
    localparam int CBW   = CHR_AW - CHR_PAGE
) (
    input  logic             split_4k,
    input  logic [4:0]       chr0,
    input  logic [4:0]       chr1,
    input  logic             upper_half,
    output logic [CBW-1:0]   bank4k
);

    logic [4:0] full;

    // Pick the 4K bank: two independent banks, or one 8K pair.
    always_comb begin
        if (split_4k)
            full = upper_half ? chr1 : chr0;
        else
            full = {chr0[4:1], upper_half};
    end

    // Truncate to the bank count present.
    always_comb bank4k = full[CBW-1:0];

endmodule

// File: rtl/cart_bank_xlate.sv
// Top of the cartridge bank address translator. Combines the window
// decoder and the two bank mappers, then registers every output.
// Assumes the configuration words are stable per cycle and that
// last_wr_chr1 is maintained by the register loader.
module cart_bank_xlate
    import cart_xlate_pkg::*;
#(
    parameter int PRG_ROM_KB = 256,
    parameter int CHR_KB     = 128,
    parameter bit FIXED32    = 1'b0,
    parameter bit REV_A      = 1'b0,
    localparam int PRG_AW    = $clog2(PRG_ROM_KB * 1024),
    localparam int CHR_AW    = $clog2(CHR_KB * 1024)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [15:0]          cpu_addr,
    input  logic [13:0]          ppu_addr,
    input  logic [4:0]           ctrl_reg,
    input  logic [4:0]           chr0_reg,
    input  logic [4:0]           chr1_reg,
    input  logic [4:0]           prg_reg,
    input  logic                 last_wr_chr1,
    output logic                 prg_sel,
    output logic [PRG_AW-1:0]    prg_addr,
    output logic                 wram_sel,
    output logic [12:0]          wram_addr,
    output logic                 chr_sel,
    output logic [CHR_AW-1:0]    chr_addr,
    output logic [1:0]           mirror,
    output logic                 wram_en
);

    localparam int BW  = PRG_AW - PRG_PAGE;
    localparam int CBW = CHR_AW - CHR_PAGE;
    localparam bit HAS_OUTER = (PRG_AW == 19);

    cpu_win_t        win;
    prg_mode_e       pmode;
    mirror_e         mir_n;
    logic            outer_bit;
    logic            en_n;
    logic [BW-1:0]   pbank;
    logic [CBW-1:0]  cbank;
    logic            chr_win;

    // Control word field split.
    always_comb begin
        pmode   = prg_mode_e'(ctrl_reg[3:2]);
        mir_n   = mirror_e'(ctrl_reg[1:0]);
        chr_win = (ppu_addr[13] == 1'b0);
    end

    generate
        if (HAS_OUTER) begin : g_outer
            // Outer program bit source: bank 1 only after a bank-1 write in 4K mode.
            always_comb outer_bit = (last_wr_chr1 && ctrl_reg[4]) ? chr1_reg[4] : chr0_reg[4];
        end else begin : g_no_outer
            // No outer bit below 512K.
            always_comb outer_bit = 1'b0;
        end
        if (REV_A) begin : g_rev_a
            // Early revision: work RAM always enabled.
            always_comb en_n = 1'b1;
        end else begin : g_rev_bc
            // Later revisions: program-bank bit 4 disables work RAM.
            always_comb en_n = ~prg_reg[4];
        end
    endgenerate

    cpu_window_dec u_win (
        .cpu_addr (cpu_addr),
        .win      (win)
    );

    prg_bank_map #(
        .PRG_AW  (PRG_AW),
        .FIXED32 (FIXED32)
    ) u_prg (
        .mode       (pmode),
        .bank       (prg_reg[3:0]),
        .outer      (outer_bit),
        .upper_half (cpu_addr[14]),
        .bank16     (pbank)
    );

    chr_bank_map #(
        .CHR_AW (CHR_AW)
    ) u_chr (
        .split_4k   (ctrl_reg[4]),
        .chr0       (chr0_reg),
        .chr1       (chr1_reg),
        .upper_half (ppu_addr[12]),
        .bank4k     (cbank)
    );

    // Output registers with synchronous reset; addresses gated by selects.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prg_sel   <= 1'b0;
            prg_addr  <= '0;
            wram_sel  <= 1'b0;
            wram_addr <= '0;
            chr_sel   <= 1'b0;
            chr_addr  <= '0;
            mirror    <= MIR_ONE_LO;
            wram_en   <= 1'b0;
        end else begin
            prg_sel   <= win.prg;
            prg_addr  <= win.prg ? {pbank, cpu_addr[PRG_PAGE-1:0]} : '0;
            wram_sel  <= win.wram && en_n;
            wram_addr <= (win.wram && en_n) ? cpu_addr[WRAM_AW-1:0] : '0;
            chr_sel   <= chr_win;
            chr_addr  <= chr_win ? {cbank, ppu_addr[CHR_PAGE-1:0]} : '0;
            mirror    <= mir_n;
            wram_en   <= en_n;
        end
    end

endmodule

// File: rtl/cart_bank_xlate_chk.sv
// Assertion checker for the cartridge bank address translator,
// attached to every instance of the top module by bind.
module cart_bank_xlate_chk #(
    parameter int PRG_AW  = 18,
    parameter int CHR_AW  = 17,
    parameter bit FIXED32 = 1'b0,
    parameter bit REV_A   = 1'b0
) (
    input logic              clk,
    input logic              rst_n,
    input logic [15:0]       cpu_addr,
    input logic [13:0]       ppu_addr,
    input logic [4:0]        ctrl_reg,
    input logic [4:0]        prg_reg,
    input logic              prg_sel,
    input logic [PRG_AW-1:0] prg_addr,
    input logic              wram_sel,
    input logic              chr_sel,
    input logic [CHR_AW-1:0] chr_addr,
    input logic [1:0]        mirror,
    input logic              wram_en
);

    localparam int BW  = PRG_AW - 14;
    localparam int IW  = (BW > 4) ? 4 : BW;

    p_mirror_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> mirror == $past(ctrl_reg[1:0]));

    p_prg_offset_r2: assert property (@(posedge clk) disable iff (!rst_n)
        prg_sel |-> prg_addr[13:0] == $past(cpu_addr[13:0]));

    p_fix_head_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (prg_sel && !FIXED32 && $past(ctrl_reg[3:2] == 2'd2 && !cpu_addr[14]))
        |-> prg_addr[14 +: IW] == '0);

    p_fix_tail_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (prg_sel && !FIXED32 && $past(ctrl_reg[3:2] == 2'd3 && cpu_addr[14]))
        |-> (&prg_addr[14 +: IW]));

    p_wram_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!REV_A && $past(prg_reg[4])) |-> !wram_sel);

    p_chr_offset_r6: assert property (@(posedge clk) disable iff (!rst_n)
        chr_sel |-> chr_addr[11:0] == $past(ppu_addr[11:0]));

    p_excl_windows_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(prg_sel && wram_sel));

    p_chr_none_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!chr_sel) |-> chr_addr == '0);

    p_fixed_board_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (FIXED32 && prg_sel) |-> prg_addr[PRG_AW-1:15] == '0);

    p_rev_a_on_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (REV_A && $past(rst_n)) |-> wram_en);

endmodule

bind cart_bank_xlate cart_bank_xlate_chk #(
    .PRG_AW  (PRG_AW),
    .CHR_AW  (CHR_AW),
    .FIXED32 (FIXED32),
    .REV_A   (REV_A)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cpu_addr (cpu_addr),
    .ppu_addr (ppu_addr),
    .ctrl_reg (ctrl_reg),
    .prg_reg  (prg_reg),
    .prg_sel  (prg_sel),
    .prg_addr (prg_addr),
    .wram_sel (wram_sel),
    .chr_sel  (chr_sel),
    .chr_addr (chr_addr),
    .mirror   (mirror),
    .wram_en  (wram_en)
);

// File: tb/sim_cart_bank_xlate.sv
module sim_cart_bank_xlate;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = 16'h0000;
    logic [13:0] ppu_addr = 14'h0000;
    logic [4:0]  ctrl_reg = 5'h00;
    logic [4:0]  chr0_reg = 5'h00;
    logic [4:0]  chr1_reg = 5'h00;
    logic [4:0]  prg_reg  = 5'h00;
    logic        last_wr_chr1 = 1'b0;

    // u0: 128K program ROM, 128K character memory
    logic        a_psel, a_wsel, a_csel, a_wen;
    logic [16:0] a_paddr;
    logic [12:0] a_waddr;
    logic [16:0] a_caddr;
    logic [1:0]  a_mir;
    // u1: 512K program ROM, 32K character memory
    logic        b_psel, b_wsel, b_csel, b_wen;
    logic [18:0] b_paddr;
    logic [12:0] b_waddr;
    logic [14:0] b_caddr;
    logic [1:0]  b_mir;
    // u2: fixed 32K board, early revision, 256K
    logic        c_psel, c_wsel, c_csel, c_wen;
    logic [17:0] c_paddr;
    logic [12:0] c_waddr;
    logic [16:0] c_caddr;
    logic [1:0]  c_mir;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cart_bank_xlate #(.PRG_ROM_KB(128), .CHR_KB(128)) u0 (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .ppu_addr(ppu_addr),
        .ctrl_reg(ctrl_reg), .chr0_reg(chr0_reg), .chr1_reg(chr1_reg),
        .prg_reg(prg_reg), .last_wr_chr1(last_wr_chr1),
        .prg_sel(a_psel), .prg_addr(a_paddr), .wram_sel(a_wsel),
        .wram_addr(a_waddr), .chr_sel(a_csel), .chr_addr(a_caddr),
        .mirror(a_mir), .wram_en(a_wen));

    cart_bank_xlate #(.PRG_ROM_KB(512), .CHR_KB(32)) u1 (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .ppu_addr(ppu_addr),
        .ctrl_reg(ctrl_reg), .chr0_reg(chr0_reg), .chr1_reg(chr1_reg),
        .prg_reg(prg_reg), .last_wr_chr1(last_wr_chr1),
        .prg_sel(b_psel), .prg_addr(b_paddr), .wram_sel(b_wsel),
        .wram_addr(b_waddr), .chr_sel(b_csel), .chr_addr(b_caddr),
        .mirror(b_mir), .wram_en(b_wen));

    cart_bank_xlate #(.PRG_ROM_KB(256), .CHR_KB(128), .FIXED32(1'b1), .REV_A(1'b1)) u2 (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .ppu_addr(ppu_addr),
        .ctrl_reg(ctrl_reg), .chr0_reg(chr0_reg), .chr1_reg(chr1_reg),
        .prg_reg(prg_reg), .last_wr_chr1(last_wr_chr1),
        .prg_sel(c_psel), .prg_addr(c_paddr), .wram_sel(c_wsel),
        .wram_addr(c_waddr), .chr_sel(c_csel), .chr_addr(c_caddr),
        .mirror(c_mir), .wram_en(c_wen));

    typedef struct packed {
        logic [4:0]  ctrl;
        logic [4:0]  chr0;
        logic [4:0]  chr1;
        logic [4:0]  prg;
        logic [15:0] cpu;
        logic [13:0] ppu;
        logic        e_psel;
        logic [16:0] e_paddr;
        logic        e_wsel;
        logic [12:0] e_waddr;
        logic        e_csel;
        logic [16:0] e_caddr;
        logic [1:0]  e_mir;
        logic        e_wen;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        // R2 mode 0, bank 5 low bit dropped, lower half; R7 8K at 0
        '{5'h00, 5'h00, 5'h00, 5'h05, 16'h8123, 14'h0456, 1'b1, 17'h10123, 1'b0, 13'h0, 1'b1, 17'h00456, 2'd0, 1'b1},
        // R2 mode 1, upper half; R7 chr0=7 -> pair 6/7, upper half
        '{5'h04, 5'h07, 5'h00, 5'h05, 16'hC123, 14'h1456, 1'b1, 17'h14123, 1'b0, 13'h0, 1'b1, 17'h07456, 2'd0, 1'b1},
        // R3 mode 2 lower half fixed to bank 0; R1 vertical
        '{5'h0A, 5'h00, 5'h00, 5'h06, 16'h8ABC, 14'h0000, 1'b1, 17'h00ABC, 1'b0, 13'h0, 1'b1, 17'h00000, 2'd2, 1'b1},
        // R3 mode 2 upper half follows bank 6
        '{5'h0A, 5'h00, 5'h00, 5'h06, 16'hCABC, 14'h0000, 1'b1, 17'h18ABC, 1'b0, 13'h0, 1'b1, 17'h00000, 2'd2, 1'b1},
        // R4 mode 3 lower half follows bank 2; R1 horizontal
        '{5'h0F, 5'h00, 5'h00, 5'h02, 16'h8001, 14'h0000, 1'b1, 17'h08001, 1'b0, 13'h0, 1'b1, 17'h00000, 2'd3, 1'b1},
        // R4 mode 3 upper half fixed to last bank 7
        '{5'h0F, 5'h00, 5'h00, 5'h02, 16'hFFFF, 14'h0000, 1'b1, 17'h1FFFF, 1'b0, 13'h0, 1'b1, 17'h00000, 2'd3, 1'b1},
        // R9 bank 11 wraps to 3 on 8 banks
        '{5'h0C, 5'h00, 5'h00, 5'h0B, 16'h9000, 14'h0000, 1'b1, 17'h0D000, 1'b0, 13'h0, 1'b1, 17'h00000, 2'd0, 1'b1},
        // R6 4K mode, lower half from chr0=3
        '{5'h1C, 5'h03, 5'h1A, 5'h00, 16'h8000, 14'h0123, 1'b1, 17'h00000, 1'b0, 13'h0, 1'b1, 17'h03123, 2'd0, 1'b1},
        // R6 4K mode, upper half from chr1=0x1A
        '{5'h1C, 5'h03, 5'h1A, 5'h00, 16'h8000, 14'h1FFF, 1'b1, 17'h00000, 1'b0, 13'h0, 1'b1, 17'h1AFFF, 2'd0, 1'b1},
        // R7 8K mode, chr1 ignored, chr0=3 -> pair 2/3, upper
        '{5'h0C, 5'h03, 5'h1A, 5'h00, 16'h8000, 14'h1234, 1'b1, 17'h00000, 1'b0, 13'h0, 1'b1, 17'h03234, 2'd0, 1'b1},
        // R5 work RAM enabled
        '{5'h0C, 5'h00, 5'h00, 5'h00, 16'h6ABC, 14'h0000, 1'b0, 17'h00000, 1'b1, 13'h0ABC, 1'b1, 17'h00000, 2'd0, 1'b1},
        // R5 work RAM disabled by bank bit 4
        '{5'h0C, 5'h00, 5'h00, 5'h10, 16'h7FFF, 14'h0000, 1'b0, 17'h00000, 1'b0, 13'h0, 1'b1, 17'h00000, 2'd0, 1'b0},
        // R10 outside all windows
        '{5'h0C, 5'h00, 5'h00, 5'h00, 16'h4020, 14'h2400, 1'b0, 17'h00000, 1'b0, 13'h0, 1'b0, 17'h00000, 2'd0, 1'b1}
    };

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual %0h expected %0h", what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic drive(input logic [4:0] c, input logic [4:0] k0, input logic [4:0] k1,
                         input logic [4:0] p, input logic [15:0] ca, input logic [13:0] pa,
                         input logic lw);
        ctrl_reg = c; chr0_reg = k0; chr1_reg = k1; prg_reg = p;
        cpu_addr = ca; ppu_addr = pa; last_wr_chr1 = lw;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        // R13 reset: inputs that would select everything, reset held
        drive(5'h1F, 5'h1F, 5'h1F, 5'h0F, 16'hC000, 14'h0100, 1'b0);
        repeat (3) step();
        chk("R13 reset prg_sel", 32'(a_psel), 32'd0);
        chk("R13 reset prg_addr", 32'(a_paddr), 32'd0);
        chk("R13 reset chr_sel", 32'(a_csel), 32'd0);
        chk("R13 reset wram_en", 32'(a_wen), 32'd0);
        chk("R1 reset mirror one-screen lower", 32'(a_mir), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            drive(VECS[i].ctrl, VECS[i].chr0, VECS[i].chr1, VECS[i].prg,
                  VECS[i].cpu, VECS[i].ppu, 1'b0);
            step();
            chk($sformatf("vec %0d prg_sel", i),   32'(a_psel),  32'(VECS[i].e_psel));
            chk($sformatf("vec %0d prg_addr", i),  32'(a_paddr), 32'(VECS[i].e_paddr));
            chk($sformatf("vec %0d wram_sel", i),  32'(a_wsel),  32'(VECS[i].e_wsel));
            chk($sformatf("vec %0d wram_addr", i), 32'(a_waddr), 32'(VECS[i].e_waddr));
            chk($sformatf("vec %0d chr_sel", i),   32'(a_csel),  32'(VECS[i].e_csel));
            chk($sformatf("vec %0d chr_addr", i),  32'(a_caddr), 32'(VECS[i].e_caddr));
            chk($sformatf("vec %0d mirror", i),    32'(a_mir),   32'(VECS[i].e_mir));
            chk($sformatf("vec %0d wram_en", i),   32'(a_wen),   32'(VECS[i].e_wen));
        end

        // R13 latency: new inputs not visible before the edge
        drive(5'h0F, 5'h00, 5'h00, 5'h02, 16'h8001, 14'h0000, 1'b0);
        step();
        chk("R13 settled prg_addr", 32'(a_paddr), 32'h08001);
        cpu_addr = 16'hC001;
        #1;
        chk("R13 held before edge", 32'(a_paddr), 32'h08001);
        step();
        chk("R13 updated after edge", 32'(a_paddr), 32'h1C001);

        // R8 outer bit from chr0 when last write was not bank 1
        drive(5'h1C, 5'h10, 5'h00, 5'h02, 16'h8000, 14'h0000, 1'b0);
        step();
        chk("R8 outer from chr0 lower half", 32'(b_paddr), 32'h48000);
        cpu_addr = 16'hC000;
        step();
        chk("R8 outer on fixed last bank", 32'(b_paddr), 32'h7C000);
        // R8 bank 1 source after a bank-1 write in 4K mode
        last_wr_chr1 = 1'b1;
        step();
        chk("R8 outer from chr1", 32'(b_paddr), 32'h3C000);
        // R8 8K mode reverts to chr0 even after a bank-1 write
        ctrl_reg = 5'h0C;
        step();
        chk("R8 8K mode uses chr0", 32'(b_paddr), 32'h7C000);

        // R9 character wrap on 8 banks of 4K
        drive(5'h1C, 5'h0B, 5'h00, 5'h00, 16'h0000, 14'h0010, 1'b0);
        step();
        chk("R9 chr bank 11 wraps to 3", 32'(b_caddr), 32'h3010);

        // R11 fixed 32K board ignores mode and bank
        drive(5'h0C, 5'h00, 5'h00, 5'h05, 16'hC001, 14'h0000, 1'b0);
        step();
        chk("R11 fixed upper half", 32'(c_paddr), 32'h04001);
        cpu_addr = 16'h8001;
        step();
        chk("R11 fixed lower half", 32'(c_paddr), 32'h00001);

        // R12 early revision keeps work RAM on with bit 4 set
        drive(5'h0C, 5'h00, 5'h00, 5'h10, 16'h6001, 14'h0000, 1'b0);
        step();
        chk("R12 wram_en stays 1", 32'(c_wen), 32'd1);
        chk("R12 wram_sel stays 1", 32'(c_wsel), 32'd1);
        chk("R12 wram_addr", 32'(c_waddr), 32'h0001);
        chk("R5 later revision disabled", 32'(a_wsel), 32'd0);

        // R13 reset mid-run clears outputs
        rst_n = 1'b0;
        step();
        chk("R13 mid-run reset wram_sel", 32'(c_wsel), 32'd0);
        chk("R1 mid-run reset mirror", 32'(a_mir), 32'd0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule